// File: doc/BRIEF.md
# Configuration lock key sequencer

This block sits behind a 32-bit lock register in a pin-configuration register file. It watches every bus access aimed at that register and follows a fixed key ritual made of three writes and one read. When the ritual completes, the per-pin mask given in the writes is frozen until reset. While the mask is frozen, the block removes the write enables that the register file would otherwise apply to the mode, output-type, speed, pull and both alternate-function fields of the locked pins.

The lock register holds sixteen pin bits in positions 15:0 and the key flag in bit 16. Bits 31:17 always read as zero. The pin bits can be written freely, byte by byte, until the key flag is set. They mean nothing to the masking logic until then. A key write carries bit 16 and the mask in one full-word write. Each of the three writes must carry the same mask, with key values 1, 0, 1 in that order. The read that follows the third write sets the key flag. Accesses to other offsets leave the tracking untouched. Any other access to the lock register sends the tracker back to idle. A write received at the read step is treated as the first write of a new attempt.

Top module: `cfg_lock_seq`

## Requirements
- R1: After reset, lock_vec is 0, key_active is 0 and lock_rdata is 0.
- R2: The following accesses, all at offset 0x1C, set the lock: a full write with bit16=1 and mask M, then a full write with bit16=0 and M, then a full write with bit16=1 and M, then a read. In the cycle after the read, key_active is 1 and lock_vec equals M.
- R3: If the second or third write carries a mask different from the first write's mask, the attempt is aborted and the closing read sets no lock.
- R4: A write to offset 0x1C is partial when bus_strb is not 4'b1111. A partial write at any step aborts the attempt.
- R5: Each of the following aborts the attempt: a read of 0x1C before the third write; a write with bit16=1 where bit16=0 is expected; a write with bit16=0 where bit16=1 is expected.
- R6: Reads or writes to any offset other than 0x1C neither advance an attempt nor abort it.
- R7: A write to 0x1C that arrives after the third write, in place of the read, is judged as a first write from idle. With bit16=1 it starts a new attempt; with bit16=0 it leaves the tracker idle.
- R8: Once key_active is 1, it stays 1 until reset. After that point, no access changes lock_vec or lock_rdata.
- R9: lock_rdata is {15'b0, key_active, pin bits}. While key_active is 0, a write to 0x1C loads pin bits 7:0 when bus_strb[0] is 1 and pin bits 15:8 when bus_strb[1] is 1.
- R10: During a bus write to offset 0x00, 0x04, 0x08, 0x0C, 0x20 or 0x24, cfg_pin_we equals cfg_pin_req & ~lock_vec. For any other access, cfg_pin_we equals cfg_pin_req. lock_vec stays 0 until key_active is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_write | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_strb | input | 4 | Byte strobes of a write access |
| lock_wdata | input | 17 | Write data bits 16:0 (bit 16 is the key, bits 15:0 are the mask) |
| cfg_pin_req | input | 16 | Pins whose fields the current configuration write would touch |
| cfg_pin_we | output | 16 | Per-pin write enable after masking by the lock |
| lock_vec | output | 16 | Frozen pin mask, zero until the key is active |
| key_active | output | 1 | Key flag, sticky until reset |
| lock_rdata | output | 32 | Read value of the lock register |

## Verification
A single write to the lock register does two things in the same cycle: it loads the pin bits and it moves the key tracker. A mismatched or partial write therefore changes the readable mask while it aborts the attempt. The bench drives such writes, by random choice and in directed cases. It then judges two results separately: the readback of the pin bits, predicted from the strobes, and the lock outcome, predicted from the kind of corruption. Sequence completion and write masking meet at the first configuration write after the closing read. The bench presents that write right away and compares cfg_pin_we against cfg_pin_req with the mask applied.

// File: rtl/cls_pkg.sv
package cls_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ARMED   = 2'd1,
    SEQ_CLEARED = 2'd2,
    SEQ_CONFIRM = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_WR_FULL = 2'd1,
    ACC_WR_PART = 2'd2,
    ACC_READ    = 2'd3
  } acc_kind_e;

  // Classify an access that hit the lock register.
  function automatic acc_kind_e classify(input logic hit, input logic write,
                                         input logic full);
    if (!hit)       return ACC_NONE;
    else if (!write) return ACC_READ;
    else if (full)   return ACC_WR_FULL;
    else             return ACC_WR_PART;
  endfunction

  // Offsets whose per-pin fields the lock freezes.
  function automatic logic offset_frozen(input logic [31:0] off);
    case (off)
      32'h00, 32'h04, 32'h08, 32'h0C, 32'h20, 32'h24: return 1'b1;
      default:                                      return 1'b0;
    endcase
  endfunction

  // One step of the key tracker.
  function automatic seq_state_e seq_step(input seq_state_e st,
                                          input acc_kind_e kind,
                                          input logic key, input logic same);
    seq_state_e nx;
    nx = st;
    case (kind)
      ACC_NONE:    nx = st;
      ACC_WR_PART: nx = SEQ_IDLE;
      ACC_READ:    nx = SEQ_IDLE;
      ACC_WR_FULL: begin
        case (st)
          SEQ_IDLE, SEQ_CONFIRM: nx = key ? SEQ_ARMED : SEQ_IDLE;
          SEQ_ARMED:             nx = (!key && same) ? SEQ_CLEARED : SEQ_IDLE;
          SEQ_CLEARED:           nx = (key && same) ? SEQ_CONFIRM : SEQ_IDLE;
          default:               nx = SEQ_IDLE;
        endcase
      end
      default: nx = SEQ_IDLE;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/cls_bus_decode.sv
module cls_bus_decode
  import cls_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int STRB_W   = 4,
  parameter int LOCK_OFF = 'h1C
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [STRB_W-1:0] bus_strb,
  input  logic              key_active,
  output acc_kind_e         acc_kind,
  output logic              lock_wr,
  output logic              cfg_frozen_wr
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(LOCK_OFF);

  logic hit_open;
  logic full_word;

  assign hit_open  = bus_valid && (bus_addr == LOCK_ADDR) && !key_active;
  assign full_word = &bus_strb;

  assign acc_kind      = classify(hit_open, bus_write, full_word);
  assign lock_wr       = hit_open && bus_write;
  assign cfg_frozen_wr = bus_valid && bus_write &&
                         offset_frozen({{(32-ADDR_W){1'b0}}, bus_addr});
endmodule

// File: rtl/cls_key_fsm.sv
module cls_key_fsm
  import cls_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  acc_kind_e       acc_kind,
  input  logic            wkey,
  input  logic [PINS-1:0] wmask,
  output seq_state_e      seq_state,
  output logic [PINS-1:0] seq_mask,
  output logic            seq_done
);
  seq_state_e state_q, state_d;
  logic [PINS-1:0] mask_q;
  logic same;

  assign same     = (wmask == mask_q);
  assign state_d  = seq_step(state_q, acc_kind, wkey, same);
  assign seq_done = (acc_kind == ACC_READ) && (state_q == SEQ_CONFIRM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      if (acc_kind == ACC_WR_FULL && state_d == SEQ_ARMED) mask_q <= wmask;
    end
  end

  assign seq_state = state_q;
  assign seq_mask  = mask_q;
endmodule

// File: rtl/cls_lock_bank.sv
module cls_lock_bank #(
  parameter int PINS   = 16,
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr,
  input  logic [STRB_W-1:0] bus_strb,
  input  logic [PINS-1:0]   wmask,
  input  logic              seq_done,
  output logic [PINS-1:0]   pin_bits,
  output logic [PINS-1:0]   lock_vec,
  output logic              key_active
);
  logic [PINS-1:0] bits_q;
  logic key_q;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      bits_q[i] <= 1'b0;
      else if (lock_wr && bus_strb[i/8]) bits_q[i] <= wmask[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        key_q <= 1'b0;
    else if (seq_done) key_q <= 1'b1;
  end

  assign pin_bits   = bits_q;
  assign key_active = key_q;
  assign lock_vec   = key_q ? bits_q : '0;
endmodule

// File: rtl/cls_we_mask.sv
module cls_we_mask #(
  parameter int PINS = 16
) (
  input  logic            cfg_frozen_wr,
  input  logic [PINS-1:0] cfg_pin_req,
  input  logic [PINS-1:0] lock_vec,
  output logic [PINS-1:0] cfg_pin_we
);
  for (genvar i = 0; i < PINS; i++) begin : g_we
    assign cfg_pin_we[i] = cfg_pin_req[i] && !(cfg_frozen_wr && lock_vec[i]);
  end
endmodule

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq
  import cls_pkg::*;
#(
  parameter int PINS     = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int LOCK_OFF = 'h1C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_strb,
  input  logic [PINS:0]       lock_wdata,
  input  logic [PINS-1:0]     cfg_pin_req,
  output logic [PINS-1:0]     cfg_pin_we,
  output logic [PINS-1:0]     lock_vec,
  output logic                key_active,
  output logic [DATA_W-1:0]   lock_rdata
);
  localparam int STRB_W = DATA_W / 8;
  localparam int PAD_W  = DATA_W - PINS - 1;

  acc_kind_e       acc_kind;
  seq_state_e      seq_state;
  logic            lock_wr;
  logic            cfg_frozen_wr;
  logic [PINS-1:0] seq_mask;
  logic            seq_done;
  logic [PINS-1:0] pin_bits;

  cls_bus_decode #(.ADDR_W(ADDR_W), .STRB_W(STRB_W), .LOCK_OFF(LOCK_OFF)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_strb(bus_strb), .key_active(key_active), .acc_kind(acc_kind),
    .lock_wr(lock_wr), .cfg_frozen_wr(cfg_frozen_wr)
  );

  cls_key_fsm #(.PINS(PINS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .wkey(lock_wdata[PINS]),
    .wmask(lock_wdata[PINS-1:0]), .seq_state(seq_state), .seq_mask(seq_mask),
    .seq_done(seq_done)
  );

  cls_lock_bank #(.PINS(PINS), .STRB_W(STRB_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr), .bus_strb(bus_strb),
    .wmask(lock_wdata[PINS-1:0]), .seq_done(seq_done), .pin_bits(pin_bits),
    .lock_vec(lock_vec), .key_active(key_active)
  );

  cls_we_mask #(.PINS(PINS)) u_mask (
    .cfg_frozen_wr(cfg_frozen_wr), .cfg_pin_req(cfg_pin_req),
    .lock_vec(lock_vec), .cfg_pin_we(cfg_pin_we)
  );

  assign lock_rdata = {{PAD_W{1'b0}}, key_active, pin_bits};
endmodule

// File: rtl/cfg_lock_seq_chk.sv
module cfg_lock_seq_chk
  import cls_pkg::*;
#(
  parameter int PINS     = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int LOCK_OFF = 'h1C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   lock_vec,
  input logic              key_active,
  input logic [DATA_W-1:0] lock_rdata,
  input seq_state_e        seq_state,
  input logic [PINS-1:0]   seq_mask,
  input logic              seq_done,
  input acc_kind_e         acc_kind
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(LOCK_OFF);

  p_key_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_active |=> key_active);

  p_lock_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_active |=> $stable(lock_vec) && $stable(lock_rdata));

  p_key_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_active) |-> $past(seq_done) && $past(bus_valid && !bus_write));

  p_lock_equals_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_active) |-> lock_vec == $past(seq_mask));

  p_partial_aborts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_WR_PART) |=> seq_state == SEQ_IDLE);

  p_other_offset_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr != LOCK_ADDR) |=> $stable(seq_state));

  p_no_lock_without_key_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !key_active |-> lock_vec == '0);

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rdata[DATA_W-1:PINS+1] == '0);
endmodule

bind cfg_lock_seq cfg_lock_seq_chk #(
  .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_OFF(LOCK_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .lock_vec(lock_vec), .key_active(key_active),
  .lock_rdata(lock_rdata), .seq_state(seq_state), .seq_mask(seq_mask),
  .seq_done(seq_done), .acc_kind(acc_kind)
);

// File: tb/cfg_lock_seq_tb.sv
module cfg_lock_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_strb = '0;
  logic [16:0] lock_wdata = '0;
  logic [15:0] cfg_pin_req = '0;
  logic [15:0] cfg_pin_we;
  logic [15:0] lock_vec;
  logic        key_active;
  logic [31:0] lock_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_lock_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .lock_wdata(lock_wdata),
    .cfg_pin_req(cfg_pin_req), .cfg_pin_we(cfg_pin_we), .lock_vec(lock_vec),
    .key_active(key_active), .lock_rdata(lock_rdata)
  );

  function automatic bit frozen_off(input logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C ||
           a == 8'h20 || a == 8'h24;
  endfunction

  function automatic logic [15:0] exp_we(input logic [7:0] a, input logic [15:0] req,
                                         input logic [15:0] lk);
    return frozen_off(a) ? (req & ~lk) : req;
  endfunction

  function automatic logic [7:0] other_off(input int unsigned k);
    case (k % 10)
      0: return 8'h00; 1: return 8'h04; 2: return 8'h08; 3: return 8'h0C;
      4: return 8'h10; 5: return 8'h14; 6: return 8'h18; 7: return 8'h20;
      8: return 8'h24; default: return 8'h28;
    endcase
  endfunction

  task automatic check(input string name, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", name, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [16:0] d,
                        input logic [3:0] s);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; lock_wdata = d; bus_strb = s;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic kwr(input bit key, input logic [15:0] m);
    access(1'b1, 8'h1C, {key, m}, 4'hF);
  endtask

  task automatic krd();
    access(1'b0, 8'h1C, '0, 4'h0);
  endtask

  task automatic cfg_check(input string name, input logic [7:0] a,
                           input logic [15:0] req, input logic [15:0] lk);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_strb = 4'hF;
    lock_wdata = '0; cfg_pin_req = req;
    #2;
    check(name, {16'h0, cfg_pin_we}, {16'h0, exp_we(a, req, lk)});
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [15:0] m;
    seed = $urandom(32'd1357);
    do_reset();

    // R1 reset state
    check("R1 lock_vec", {16'h0, lock_vec}, 32'h0);
    check("R1 key_active", {31'h0, key_active}, 32'h0);
    check("R1 lock_rdata", lock_rdata, 32'h0);

    // R9 byte-wise pin bit writes and readback layout
    access(1'b1, 8'h1C, 17'h000A5, 4'b0001);
    check("R9 low byte", lock_rdata, 32'h0000_00A5);
    access(1'b1, 8'h1C, 17'h13C77, 4'b0010);
    check("R9 high byte", lock_rdata, 32'h0000_3CA5);
    access(1'b1, 8'h1C, 17'h1FFFF, 4'hF);
    check("R9 key bit not direct", lock_rdata, 32'h0000_FFFF);

    // R10 pin bits set but no key: nothing blocked
    cfg_check("R10 unlocked pass", 8'h00, 16'hFFFF, 16'h0000);

    // R2 + R6 full sequence with foreign accesses interleaved
    do_reset();
    kwr(1'b1, 16'h5A3C);
    access(1'b0, 8'h10, '0, 4'h0);
    kwr(1'b0, 16'h5A3C);
    access(1'b1, 8'h04, 17'h1FFFF, 4'hF);
    kwr(1'b1, 16'h5A3C);
    access(1'b1, 8'h24, 17'h00000, 4'b0001);
    krd();
    check("R2 key_active", {31'h0, key_active}, 32'h1);
    check("R2 lock_vec", {16'h0, lock_vec}, 32'h0000_5A3C);
    check("R9 readback with key", lock_rdata, 32'h0001_5A3C);

    // R10 masking right after the lock, then on other offsets
    cfg_check("R10 mode blocked", 8'h00, 16'hFFFF, 16'h5A3C);
    cfg_check("R10 otype blocked", 8'h04, 16'hFFFF, 16'h5A3C);
    cfg_check("R10 afh blocked", 8'h24, 16'h0F0F, 16'h5A3C);
    cfg_check("R10 data pass", 8'h14, 16'hFFFF, 16'h5A3C);

    // R8 sticky lock
    kwr(1'b0, 16'h0000);
    access(1'b1, 8'h1C, 17'h0FFFF, 4'b0011);
    kwr(1'b1, 16'h1111); kwr(1'b0, 16'h1111); kwr(1'b1, 16'h1111); krd();
    check("R8 lock_vec held", {16'h0, lock_vec}, 32'h0000_5A3C);
    check("R8 rdata held", lock_rdata, 32'h0001_5A3C);

    do_reset();
    check("R1 after second reset", lock_rdata, 32'h0);

    // R7 write at read step restarts from idle
    kwr(1'b1, 16'h00F0); kwr(1'b0, 16'h00F0); kwr(1'b1, 16'h00F0);
    kwr(1'b1, 16'h0F00); kwr(1'b0, 16'h0F00); kwr(1'b1, 16'h0F00); krd();
    check("R7 restart locks", {15'h0, key_active, lock_vec}, 32'h0001_0F00);
    do_reset();
    kwr(1'b1, 16'h00F0); kwr(1'b0, 16'h00F0); kwr(1'b1, 16'h00F0);
    kwr(1'b0, 16'h00F0); krd();
    check("R7 key0 at read step", {31'h0, key_active}, 32'h0);

    // R5 ordering errors
    do_reset();
    kwr(1'b1, 16'h1234); kwr(1'b0, 16'h1234); krd(); kwr(1'b1, 16'h1234); krd();
    check("R5 early read", {31'h0, key_active}, 32'h0);
    do_reset();
    kwr(1'b1, 16'h1234); kwr(1'b1, 16'h1234); kwr(1'b1, 16'h1234); krd();
    check("R5 key1 where key0 expected", {31'h0, key_active}, 32'h0);
    do_reset();
    kwr(1'b1, 16'h1234); kwr(1'b0, 16'h1234); kwr(1'b0, 16'h1234); krd();
    check("R5 key0 where key1 expected", {31'h0, key_active}, 32'h0);

    // R3 mask change, R4 partial write (directed)
    do_reset();
    kwr(1'b1, 16'hAAAA); kwr(1'b0, 16'hAAAA); kwr(1'b1, 16'hAAAB); krd();
    check("R3 mask change", {31'h0, key_active}, 32'h0);
    check("R3 pin bits follow write", lock_rdata, 32'h0000_AAAB);
    do_reset();
    kwr(1'b1, 16'hAAAA); access(1'b1, 8'h1C, 17'h0AAAA, 4'b0111);
    kwr(1'b1, 16'hAAAA); krd();
    check("R4 partial write", {31'h0, key_active}, 32'h0);

    // Random attempts: 0 clean, 1 mask change, 2 partial, 3 early read, 4 foreign access
    for (int it = 0; it < 60; it++) begin
      int unsigned t, pos, bitn;
      bit expl;
      logic [15:0] m2, m3;
      logic [3:0] s1, s2, s3;
      do_reset();
      m = 16'($urandom());
      t = $urandom() % 5;
      pos = $urandom() % 3;
      bitn = $urandom() % 16;
      m2 = m; m3 = m;
      s1 = 4'hF; s2 = 4'hF; s3 = 4'hF;
      if (t == 1) begin
        if (pos == 0) m2 = m ^ (16'h1 << bitn); else m3 = m ^ (16'h1 << bitn);
      end
      if (t == 2) begin
        if (pos == 0) s1 = 4'b0011; else if (pos == 1) s2 = 4'b1101; else s3 = 4'b0001;
      end
      access(1'b1, 8'h1C, {1'b1, m}, s1);
      if (t == 3) krd();
      if (t == 4) access(1'($urandom()), other_off($urandom()), 17'($urandom()), 4'hF);
      access(1'b1, 8'h1C, {1'b0, m2}, s2);
      if (t == 4) access(1'($urandom()), other_off($urandom()), 17'($urandom()), 4'hF);
      access(1'b1, 8'h1C, {1'b1, m3}, s3);
      krd();
      expl = (t == 0) || (t == 4);
      check($sformatf("R2 R3 R4 R5 R6 random key t=%0d", t), {31'h0, key_active},
            {31'h0, expl});
      check($sformatf("R2 random lock_vec t=%0d", t), {16'h0, lock_vec},
            {16'h0, expl ? m : 16'h0});
      if (expl) cfg_check("R10 random mask", other_off($urandom()), 16'($urandom()), m);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule